// File: doc/BRIEF.md
# Host I/O Front End with Gated Station-Address PROM

This block sits between a host I/O window and a small network controller. Each request carries a byte offset, a size code for 1, 2 or 4 bytes, a direction and write data. Offsets below 16 land in a 16-byte station-address PROM. Offsets of 16 and above are handed to the controller's register port, which lies outside this block.

Whether a PROM access is taken depends on the access size, on its alignment and on a mode input that selects word or doubleword I/O. Stores into the PROM also need a separate write-enable input. Both mode inputs come from the controller's register block.

Any read that is not taken returns all ones at the requested width. Any write that is not taken is dropped. Read data and its valid flag come back one cycle after the request. Both are registered.

Top module: `prom_window_io`

## Requirements
- R1: After reset, PROM byte k (k = 0..5) holds bits 8k+7:8k of the STATION_ADDR parameter. Bytes 6..15 hold the PAD_BYTES parameter, with byte 6 at its bits 7:0. `rsp_valid` is low after reset.
- R2: A read request gives `rsp_valid` high for exactly the next cycle, with `rsp_rdata` in that same cycle. A write request gives no `rsp_valid`.
- R3: With `dword_io` low, a 1-byte PROM access (size code 0) is taken at any offset 0..15. The read byte appears in bits 7:0.
- R4: With `dword_io` low, a 2-byte access (size code 1) is taken only at an even offset. It covers bytes at offset and offset+1, with the lower offset in bits 7:0.
- R5: With `dword_io` high, only a 4-byte access (size code 2) at an offset that is a multiple of 4 is taken in the PROM window. It covers four bytes in little-endian order. A 4-byte access is never taken with `dword_io` low.
- R6: A taken PROM write changes the stored bytes only while `prom_we` is high. PROM reads are taken whatever the value of `prom_we`.
- R7: A read that is not taken returns 0xFF for size 0, 0x0000FFFF for size 1, and 0xFFFFFFFF for size 2. Size code 3 is never taken and reads 0xFFFFFFFF.
- R8: At offsets 16 and above, a request of size 1 or 2 drives `reg_valid` in the same cycle. It also passes offset, size, direction and write data unchanged. The read reply is `reg_rdata` masked to the access width.
- R9: At offsets 16 and above, a 1-byte request is not forwarded (`reg_valid` low). It reads 0xFF.
- R10: A PROM write that is not taken, whether by size, alignment or mode, leaves every PROM byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = invalid |
| req_wdata | input | 32 | Write data, little-endian |
| dword_io | input | 1 | 1 = doubleword I/O mode |
| prom_we | input | 1 | PROM write enable |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| reg_valid | output | 1 | Register-port request strobe |
| reg_write | output | 1 | Register-port direction |
| reg_addr | output | ADDR_W | Register-port offset |
| reg_size | output | 2 | Register-port size code |
| reg_wdata | output | 32 | Register-port write data |
| reg_rdata | input | 32 | Register-port read data, combinational |

## Verification
The hardest case is a write that is not taken. It leaves no trace at the moment it happens. To expose it, the bench writes while `prom_we` is high, using an odd offset, a wrong size and a wrong mode. It then reads the touched bytes back through an accepted access and compares them with its own byte image.

Lane rotation errors only show when multi-byte reads start at non-zero offsets. For that reason, 2-byte reads are walked through every even offset, and the PROM is preloaded with bytes that are all different.

// File: rtl/prom_io_pkg.sv
package prom_io_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int LW     = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_BAD  = 2'd3
  } size_e;

  function automatic logic [DATA_W-1:0] width_ones(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: width_ones = 32'h0000_00FF;
      SZ_HALF: width_ones = 32'h0000_FFFF;
      default: width_ones = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/prom_access_decode.sv
module prom_access_decode
  import prom_io_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int WIN_BYTES = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              dword_io,
  output logic              prom_ok,
  output logic              fwd_ok,
  output logic [LANES-1:0]  lane_be,
  output logic [DATA_W-1:0] wmask
);
  logic          in_win;
  logic [LW-1:0] off;

  assign in_win = addr < ADDR_W'(WIN_BYTES);
  assign off    = addr[LW-1:0];

  always_comb begin
    prom_ok = 1'b0;
    if (in_win) begin
      if (!dword_io) begin
        if (size == SZ_BYTE)                  prom_ok = 1'b1;
        else if (size == SZ_HALF && !addr[0]) prom_ok = 1'b1;
      end else if (size == SZ_WORD && off == '0) begin
        prom_ok = 1'b1;
      end
    end
  end

  assign fwd_ok = !in_win && (size == SZ_HALF || size == SZ_WORD);

  always_comb begin
    case (size)
      SZ_BYTE: lane_be = LANES'(1) << off;
      SZ_HALF: lane_be = LANES'(3) << off;
      default: lane_be = '1;
    endcase
  end

  assign wmask = width_ones(size);
endmodule

// File: rtl/prom_lane.sv
module prom_lane #(
  parameter int                   ROWS = 4,
  parameter int                   RW   = 2,
  parameter logic [8*ROWS-1:0]    INIT = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [RW-1:0] row,
  input  logic [7:0]    wbyte,
  output logic [7:0]    rbyte
);
  logic [7:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= INIT[8*r +: 8];
    end else if (we) begin
      mem[row] <= wbyte;
    end
  end

  assign rbyte = mem[row];
endmodule

// File: rtl/prom_window_io.sv
module prom_window_io
  import prom_io_pkg::*;
#(
  parameter int                        ADDR_W       = 8,
  parameter int                        WIN_BYTES    = 16,
  parameter logic [47:0]               STATION_ADDR = 48'h5634_1200_0A08,
  parameter logic [8*WIN_BYTES-49:0]   PAD_BYTES    = 80'hA9A8_A7A6_A5A4_A3A2_A1A0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  input  logic              dword_io,
  input  logic              prom_we,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              reg_valid,
  output logic              reg_write,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [1:0]        reg_size,
  output logic [31:0]       reg_wdata,
  input  logic [31:0]       reg_rdata
);
  localparam int ROWS = WIN_BYTES / LANES;
  localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam logic [8*WIN_BYTES-1:0] INIT_ALL = {PAD_BYTES, STATION_ADDR};

  function automatic logic [8*ROWS-1:0] lane_init(input int lane);
    logic [8*ROWS-1:0] v;
    v = '0;
    for (int r = 0; r < ROWS; r++) v[8*r +: 8] = INIT_ALL[8*(r*LANES+lane) +: 8];
    return v;
  endfunction

  logic              prom_ok, fwd_ok;
  logic [LANES-1:0]  lane_be;
  logic [DATA_W-1:0] wmask;
  logic [LW-1:0]     off;
  logic [RW-1:0]     row;
  logic              wr_fire;
  logic [7:0]        lane_rbyte [LANES];
  logic [DATA_W-1:0] prom_word;

  prom_access_decode #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) u_dec (
    .addr(req_addr), .size(req_size), .dword_io(dword_io),
    .prom_ok(prom_ok), .fwd_ok(fwd_ok), .lane_be(lane_be), .wmask(wmask)
  );

  assign off     = req_addr[LW-1:0];
  assign row     = RW'(req_addr >> LW);
  assign wr_fire = req_valid && req_write && prom_ok && prom_we;

  for (genvar L = 0; L < LANES; L++) begin : g_lane
    localparam logic [LW-1:0] LID = LW'(L);
    logic [LW-1:0] src, rsel;
    logic [7:0]    wbyte;

    assign src   = LID - off;
    assign rsel  = off + LID;
    assign wbyte = req_wdata[{src, 3'b000} +: 8];

    prom_lane #(.ROWS(ROWS), .RW(RW), .INIT(lane_init(L))) u_lane (
      .clk(clk), .rst(rst), .we(wr_fire && lane_be[L]),
      .row(row), .wbyte(wbyte), .rbyte(lane_rbyte[L])
    );

    assign prom_word[8*L +: 8] = lane_rbyte[rsel];
  end

  assign reg_valid = req_valid && fwd_ok;
  assign reg_write = req_write;
  assign reg_addr  = req_addr;
  assign reg_size  = req_size;
  assign reg_wdata = req_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) begin
        if (prom_ok)     rsp_rdata <= prom_word & wmask;
        else if (fwd_ok) rsp_rdata <= reg_rdata & wmask;
        else             rsp_rdata <= wmask;
      end
    end
  end

  p_read_gets_rsp_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rsp_valid);

  p_write_no_rsp_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> !rsp_valid);

  p_fwd_above_window_r8: assert property (@(posedge clk) disable iff (rst)
    reg_valid |-> (req_addr >= ADDR_W'(WIN_BYTES)));

  p_no_byte_fwd_r9: assert property (@(posedge clk) disable iff (rst)
    reg_valid |-> (reg_size != SZ_BYTE));

  p_dword_only_aligned_r5: assert property (@(posedge clk) disable iff (rst)
    (prom_ok && dword_io) |-> (req_size == SZ_WORD && off == '0));

  p_reject_all_ones_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && !prom_ok && !fwd_ok) |=>
      (rsp_rdata == width_ones($past(req_size))));
endmodule

// File: tb/prom_window_io_test.sv
module prom_window_io_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        dword_io = 1'b0, prom_we = 1'b0;
  logic        rsp_valid, reg_valid, reg_write;
  logic [31:0] rsp_rdata, reg_wdata, reg_rdata;
  logic [7:0]  reg_addr;
  logic [1:0]  reg_size;

  int nvec = 0, nerr = 0, cycles = 0;
  logic [7:0] img [16];

  always #2.5 clk = ~clk;

  assign reg_rdata = {8'hC3, reg_addr, 8'h3C, ~reg_addr};

  prom_window_io uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .dword_io(dword_io), .prom_we(prom_we), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_size(reg_size), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  function automatic logic [31:0] mask_of(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic bit taken(input logic [7:0] a, input logic [1:0] sz);
    if (a >= 8'd16) return 1'b0;
    if (!dword_io) return (sz == 2'd0) || (sz == 2'd1 && a[0] == 1'b0);
    return (sz == 2'd2) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic [31:0] model_rd(input logic [7:0] a, input logic [1:0] sz);
    logic [31:0] v;
    v = '0;
    if (taken(a, sz)) begin
      for (int i = 0; i < nbytes(sz); i++) v[8*i +: 8] = img[a + 8'(i)];
      return v;
    end
    if (a >= 8'd16 && (sz == 2'd1 || sz == 2'd2))
      return {8'hC3, a, 8'h3C, ~a} & mask_of(sz);
    return mask_of(sz);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [1:0] sz);
    logic [31:0] exp;
    bit fwd;
    exp = model_rd(a, sz);
    fwd = (a >= 8'd16) && (sz == 2'd1 || sz == 2'd2);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
    #0.5;
    chk({tag, " reg_valid"}, 32'(reg_valid), 32'(fwd));
    @(negedge clk);
    req_valid = 1'b0;
    chk({"R2 rsp_valid ", tag}, 32'(rsp_valid), 32'd1);
    chk({tag, " data"}, rsp_rdata, exp);
    @(negedge clk);
    chk("R2 rsp_valid drop", 32'(rsp_valid), 32'd0);
  endtask

  task automatic wr(input string tag, input logic [7:0] a, input logic [1:0] sz,
                    input logic [31:0] d);
    bit fwd;
    fwd = (a >= 8'd16) && (sz == 2'd1 || sz == 2'd2);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
    #0.5;
    chk({tag, " reg_valid"}, 32'(reg_valid), 32'(fwd));
    if (fwd) begin
      chk("R8 reg_write", 32'(reg_write), 32'd1);
      chk("R8 reg_wdata", reg_wdata, d);
      chk("R8 reg_addr", 32'(reg_addr), 32'(a));
    end
    if (taken(a, sz) && prom_we)
      for (int i = 0; i < nbytes(sz); i++) img[a + 8'(i)] = d[8*i +: 8];
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk("R2 no rsp on write", 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    dword_io = 1'b0;
    for (int k = 0; k < 16; k++) rd("R1 R3 byte read", 8'(k), 2'd0);
  endtask

  task automatic t_word_mode();
    dword_io = 1'b0;
    for (int k = 0; k < 16; k += 2) rd("R4 half even", 8'(k), 2'd1);
    rd("R4 R7 half odd", 8'd3, 2'd1);
    rd("R5 R7 word in word mode", 8'd4, 2'd2);
    rd("R7 size code 3", 8'd0, 2'd3);
  endtask

  task automatic t_dword_mode();
    @(negedge clk); dword_io = 1'b1;
    for (int k = 0; k < 16; k += 4) rd("R5 word aligned", 8'(k), 2'd2);
    rd("R5 R7 word misaligned", 8'd2, 2'd2);
    rd("R5 R7 byte in dword", 8'd1, 2'd0);
    rd("R5 R7 half in dword", 8'd4, 2'd1);
  endtask

  task automatic t_write_enable();
    @(negedge clk); dword_io = 1'b1; prom_we = 1'b0;
    wr("R6 gated write", 8'd8, 2'd2, 32'hDEAD_BEEF);
    rd("R6 unchanged after gated write", 8'd8, 2'd2);
    @(negedge clk); prom_we = 1'b1;
    wr("R6 enabled word write", 8'd8, 2'd2, 32'h1357_9BDF);
    rd("R6 word readback", 8'd8, 2'd2);
    @(negedge clk); dword_io = 1'b0;
    wr("R6 R3 byte write", 8'd13, 2'd0, 32'h0000_0077);
    wr("R6 R4 half write", 8'd6, 2'd1, 32'h0000_C4B5);
    rd("R4 half readback", 8'd6, 2'd1);
    rd("R3 byte readback", 8'd13, 2'd0);
    rd("R4 straddle readback", 8'd12, 2'd1);
    @(negedge clk); prom_we = 1'b0;
    rd("R6 read with we low", 8'd6, 2'd1);
  endtask

  task automatic t_rejected_writes();
    @(negedge clk); prom_we = 1'b1; dword_io = 1'b0;
    wr("R10 odd half write", 8'd5, 2'd1, 32'h0000_EEEE);
    wr("R10 word write in word mode", 8'd0, 2'd2, 32'hEEEE_EEEE);
    wr("R10 size 3 write", 8'd0, 2'd3, 32'hEEEE_EEEE);
    @(negedge clk); dword_io = 1'b1;
    wr("R10 byte write in dword", 8'd1, 2'd0, 32'h0000_00EE);
    wr("R10 misaligned word write", 8'd6, 2'd2, 32'hEEEE_EEEE);
    for (int k = 0; k < 16; k += 4) rd("R10 image intact", 8'(k), 2'd2);
    @(negedge clk); prom_we = 1'b0;
  endtask

  task automatic t_forward();
    @(negedge clk); dword_io = 1'b0;
    rd("R8 half forward read", 8'h20, 2'd1);
    rd("R8 word forward read", 8'h44, 2'd2);
    wr("R8 word forward write", 8'h48, 2'd2, 32'hA5A5_0F0F);
    wr("R8 half forward write", 8'h10, 2'd1, 32'h0000_1234);
    rd("R9 byte above window", 8'h30, 2'd0);
    wr("R9 byte write above window", 8'h31, 2'd0, 32'h0000_0055);
    rd("R9 size 3 above window", 8'h40, 2'd3);
    @(negedge clk); dword_io = 1'b1;
    rd("R8 forward in dword mode", 8'h12, 2'd1);
  endtask

  initial begin
    logic [7:0] init_b [16] = '{8'h08, 8'h0A, 8'h00, 8'h12, 8'h34, 8'h56,
                                8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5,
                                8'hA6, 8'hA7, 8'hA8, 8'hA9};
    for (int k = 0; k < 16; k++) img[k] = init_b[k];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_word_mode();
    t_dword_mode();
    t_write_enable();
    t_rejected_writes();
    t_forward();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        nvec++; nerr++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        finish_run();
      end
    end
  end
endmodule